// File: doc/BRIEF.md
# Cascadable column-driver data sampler

This block is the digital input stage of a display column driver that is built to be chained with copies of itself. It sits idle until a one-cycle start pulse arrives on its enable input. From the next clock edge on, it takes one group of six 8-bit grey-scale words per rising edge into a bank of 384 channel registers. Sixty-four groups fill the bank. Before each word is stored, it can be bit-inverted: one control covers the lower half of the lanes and a second control covers the upper half.

A direction pin controls two things. It sets whether the groups fill the bank from the lowest channels upward or from the highest channels downward. It also sets which of the two enable ports is the input and which is the output. One edge before the final group is captured, the block raises its enable output for exactly one cycle. The next driver in the chain samples that pulse and starts capturing on the edge right after this block's last capture, so there is no idle cycle on the shared data bus. After the last group the block returns to idle and ignores the bus. The channel bank is brought out in full, so that a later load stage can copy it.

Top module: `cds_sampler`

## Requirements
- R1: A synchronous active-low reset puts the block in idle. Both enable outputs are low and every channel of the bank reads zero.
- R2: While idle, a high on the enable input is sampled on a rising edge, and the first group is captured on the next rising edge. The enable input is port A when `dir_up` is 1 and port B when `dir_up` is 0. A high on the other port has no effect.
- R3: One transfer captures exactly 64 groups of six lanes, one group per rising edge, which fills all 384 channels. Channel c occupies bits [8c+7:8c] of `bank_flat`, numbered from 0.
- R4: With `dir_up` at 1, group g (counted from 0) writes lane n to channel 6g+n.
- R5: With `dir_up` at 0, group g writes lane n to channel 6(63-g)+n. Lane 0 of the first group therefore lands in channel 378.
- R6: Lanes 0 to 2 (bus bits [23:0], lane n at [8n+7:8n]) are XORed with `inv_lo` before they are stored.
- R7: Lanes 3 to 5 (bus bits [47:24]) are XORed with `inv_hi` before they are stored.
- R8: The enable output rises on the edge that captures group 62 and falls on the edge that captures group 63, so it is high for exactly one cycle. The enable output is port B when `dir_up` is 1 and port A when `dir_up` is 0.
- R9: After group 63 the block is idle, and the bus and the inversion inputs leave the bank unchanged.
- R10: A start pulse that arrives during a transfer is ignored. The transfer neither restarts nor lengthens.
- R11: The enable port that is not the current output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_up | input | 1 | 1: fill upward, A in / B out; 0: fill downward, B in / A out |
| port_a_i | input | 1 | Enable port A, input side |
| port_b_i | input | 1 | Enable port B, input side |
| port_a_o | output | 1 | Enable port A, output side |
| port_b_o | output | 1 | Enable port B, output side |
| inv_lo | input | 1 | Invert lanes 0 to 2 |
| inv_hi | input | 1 | Invert lanes 3 to 5 |
| pix_bus | input | 48 | Six 8-bit grey-scale words, lane n at [8n+7:8n] |
| bank_flat | output | 3072 | All 384 channel registers, channel c at [8c+7:8c] |

## Verification
On every cycle, the assertions check the following. Reset forces idle. The carry pulse lasts one cycle and starts only while the last group is pending. The sequencer leaves the transfer once group 63 is done and otherwise advances by one. The bank holds still whenever no capture is under way. The lane-to-channel mapping in both directions, the inversion applied per half, and which port acts as input and which as output can only be shown by the bench's scenarios. These scenarios cover an upward and a downward frame, inversion that changes from group to group, a start pulse on the wrong port, a second start pulse in the middle of a frame, and bus activity after a frame.

// File: rtl/cds_pkg.sv
// Shared types for the cascadable sampler.
// Assumes: nothing beyond IEEE 1800-2017.
package cds_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/cds_seq_ctrl.sv
// Transfer sequencer: waits for a start, counts GROUPS captures and raises
// a one-cycle carry on the capture before the last.
// Assumes: GROUPS >= 2; start is a single-cycle pulse.
module cds_seq_ctrl
    import cds_pkg::*;
#(
    parameter  int GROUPS = 64,
    localparam int GW     = $clog2(GROUPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [GW-1:0] grp,
    output logic          carry
);
    localparam logic [GW-1:0] LAST   = GW'(GROUPS - 1);
    localparam logic [GW-1:0] PENULT = GW'(GROUPS - 2);

    run_state_e st;

    // State, group counter and carry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            grp   <= '0;
            carry <= 1'b0;
        end else begin
            carry <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_RUN;
                        grp <= '0;
                    end
                end
                ST_RUN: begin
                    if (grp == PENULT) carry <= 1'b1;
                    if (grp == LAST) begin
                        st  <= ST_IDLE;
                        grp <= '0;
                    end else begin
                        grp <= grp + GW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture is enabled for the whole run state.
    always_comb busy = (st == ST_RUN);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && grp == '0 && !carry));

    assert_carry_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);

    assert_carry_before_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry) |-> (busy && grp == LAST));

    assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp == LAST) |=> !busy);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp != LAST) |=> (busy && grp == $past(grp) + GW'(1)));
endmodule

// File: rtl/cds_lane_inv.sv
// Per-lane conditional inversion: lanes below LANES/2 follow inv_lo,
// the rest follow inv_hi.
// Assumes: LANES is even.
module cds_lane_inv #(
    parameter int LANES  = 6,
    parameter int WORD_W = 8
) (
    input  logic [LANES*WORD_W-1:0] pix_in,
    input  logic                    inv_lo,
    input  logic                    inv_hi,
    output logic [LANES*WORD_W-1:0] pix_out
);
    localparam int HALF = LANES / 2;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        localparam bit LOW_HALF = (n < HALF);
        logic flip;
        // Select the inversion control for this lane.
        always_comb flip = LOW_HALF ? inv_lo : inv_hi;
        // Apply the XOR to the lane word.
        always_comb pix_out[n*WORD_W +: WORD_W] =
            pix_in[n*WORD_W +: WORD_W] ^ {WORD_W{flip}};
    end
endmodule

// File: rtl/cds_sample_bank.sv
// Channel register bank: each channel knows its group and lane and takes
// its lane word when that group is captured in the current direction.
// Assumes: grp < GROUPS whenever we is high.
module cds_sample_bank #(
    parameter  int GROUPS = 64,
    parameter  int LANES  = 6,
    parameter  int WORD_W = 8,
    localparam int GW     = $clog2(GROUPS),
    localparam int CHANS  = GROUPS * LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    dir_up,
    input  logic [GW-1:0]           grp,
    input  logic [LANES*WORD_W-1:0] words,
    output logic [CHANS*WORD_W-1:0] bank_flat
);
    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        localparam int            LANE   = c % LANES;
        localparam logic [GW-1:0] G_UP   = GW'(c / LANES);
        localparam logic [GW-1:0] G_DOWN = GW'(GROUPS - 1 - c / LANES);
        logic hit;
        // Decide whether this channel is addressed in the present cycle.
        always_comb hit = we && (grp == (dir_up ? G_UP : G_DOWN));
        // Store the lane word when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)   bank_flat[c*WORD_W +: WORD_W] <= '0;
            else if (hit) bank_flat[c*WORD_W +: WORD_W] <= words[LANE*WORD_W +: WORD_W];
        end
    end

    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_flat));
endmodule

// File: rtl/cds_sampler.sv
// Top of the cascadable sampler: routes the enable ports by direction,
// inverts the bus per half and writes the channel bank.
// Assumes: dir_up is static during a transfer.
module cds_sampler #(
    parameter  int GROUPS = 64,
    parameter  int LANES  = 6,
    parameter  int WORD_W = 8,
    localparam int CHANS  = GROUPS * LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dir_up,
    input  logic                    port_a_i,
    input  logic                    port_b_i,
    output logic                    port_a_o,
    output logic                    port_b_o,
    input  logic                    inv_lo,
    input  logic                    inv_hi,
    input  logic [LANES*WORD_W-1:0] pix_bus,
    output logic [CHANS*WORD_W-1:0] bank_flat
);
    localparam int GW = $clog2(GROUPS);

    logic                    start;
    logic                    busy;
    logic                    carry;
    logic [GW-1:0]           grp;
    logic [LANES*WORD_W-1:0] words;

    // Pick the enable input by direction.
    always_comb start = dir_up ? port_a_i : port_b_i;

    // Send the carry out on the opposite port; the unused one stays low.
    always_comb begin
        port_b_o = dir_up & carry;
        port_a_o = ~dir_up & carry;
    end

    cds_seq_ctrl #(.GROUPS(GROUPS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .grp   (grp),
        .carry (carry)
    );

    cds_lane_inv #(.LANES(LANES), .WORD_W(WORD_W)) u_inv (
        .pix_in  (pix_bus),
        .inv_lo  (inv_lo),
        .inv_hi  (inv_hi),
        .pix_out (words)
    );

    cds_sample_bank #(.GROUPS(GROUPS), .LANES(LANES), .WORD_W(WORD_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (busy),
        .dir_up    (dir_up),
        .grp       (grp),
        .words     (words),
        .bank_flat (bank_flat)
    );
endmodule

// File: tb/cds_sampler_tb.sv
module cds_sampler_tb;
    localparam int GROUPS = 64;
    localparam int LANES  = 6;
    localparam int W      = 8;
    localparam int CHANS  = GROUPS * LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up = 1'b1;
    logic port_a_i = 1'b0, port_b_i = 1'b0;
    logic port_a_o, port_b_o;
    logic inv_lo = 1'b0, inv_hi = 1'b0;
    logic [LANES*W-1:0] pix_bus = '0;
    logic [CHANS*W-1:0] bank_flat;

    always #10 clk = ~clk;

    cds_sampler u_dut (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up),
        .port_a_i(port_a_i), .port_b_i(port_b_i),
        .port_a_o(port_a_o), .port_b_o(port_b_o),
        .inv_lo(inv_lo), .inv_hi(inv_hi),
        .pix_bus(pix_bus), .bank_flat(bank_flat)
    );

    typedef struct {
        int          ch;
        logic [7:0]  val;
        string       tag;
    } sb_item_t;

    sb_item_t   sb_q[$];
    logic [7:0] model [CHANS];
    int checks = 0;
    int errors = 0;
    bit done   = 0;
    event frame_done;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: pops expected captures and compares them with the bank.
    initial begin
        forever begin
            @(frame_done);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(bank_flat[it.ch*W +: W] == it.val, it.tag, $sformatf("channel %0d", it.ch),
                      int'(bank_flat[it.ch*W +: W]), int'(it.val));
            end
        end
    end

    task automatic compare_all(string tag, string what);
        int bad = 0, first = -1;
        for (int c = 0; c < CHANS; c++) begin
            if (bank_flat[c*W +: W] !== model[c]) begin
                bad++;
                if (first < 0) first = c;
            end
        end
        if (first < 0) check(1'b1, tag, what, 0, 0);
        else check(1'b0, tag, $sformatf("%s ch %0d", what, first),
                   int'(bank_flat[first*W +: W]), int'(model[first]));
    endtask

    function automatic logic [7:0] word_of(int g, int l, int seed);
        return 8'((g * 7 + l * 37 + seed * 11) & 8'hff);
    endfunction

    task automatic check_ports(bit dir, bit exp_carry, string what);
        logic out_p, idle_p;
        out_p  = dir ? port_b_o : port_a_o;
        idle_p = dir ? port_a_o : port_b_o;
        check(out_p == exp_carry, "R8", what, int'(out_p), int'(exp_carry));
        check(idle_p == 1'b0, "R11", what, int'(idle_p), 0);
    endtask

    // Driver: runs one full transfer and queues the expected captures.
    task automatic run_frame(bit dir, int seed, bit spurious);
        @(negedge clk);
        dir_up = dir;
        if (dir) port_a_i = 1'b1; else port_b_i = 1'b1;
        pix_bus = '1;
        for (int g = 0; g < GROUPS; g++) begin
            @(negedge clk);
            port_a_i = 1'b0;
            port_b_i = 1'b0;
            if (spurious && g == 10) begin
                if (dir) port_a_i = 1'b1; else port_b_i = 1'b1;   // R10 mid-frame start
            end
            check_ports(dir, g == GROUPS - 1, $sformatf("carry before group %0d", g));
            inv_lo = 1'(g ^ seed);
            inv_hi = 1'((g >> 1) ^ seed);
            for (int l = 0; l < LANES; l++) begin
                sb_item_t it;
                logic [7:0] w;
                w = word_of(g, l, seed);
                pix_bus[l*W +: W] = w;
                it.ch  = dir ? g * LANES + l : (GROUPS - 1 - g) * LANES + l;
                it.val = w ^ {8{(l < LANES/2) ? inv_lo : inv_hi}};
                it.tag = (l < LANES/2) ? (dir ? "R4/R6" : "R5/R6") : (dir ? "R4/R7" : "R5/R7");
                model[it.ch] = it.val;
                sb_q.push_back(it);
            end
        end
        @(negedge clk);
        port_a_i = 1'b0;
        port_b_i = 1'b0;
        check_ports(dir, 1'b0, "carry after last capture");
        ->frame_done;
        wait (sb_q.size() == 0);
        compare_all("R3", "full bank after frame");
        // R9: bus activity while idle must not write the bank
        for (int k = 0; k < 5; k++) begin
            pix_bus = {6{8'(8'h5a + k)}};
            inv_lo  = 1'(k);
            inv_hi  = ~1'(k);
            @(negedge clk);
            check_ports(dir, 1'b0, "idle after frame");
        end
        compare_all(spurious ? "R10" : "R9", "bank after idle bus traffic");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < CHANS; c++) model[c] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(port_a_o == 1'b0 && port_b_o == 1'b0, "R1", "enable outputs in reset",
              int'({port_a_o, port_b_o}), 0);
        compare_all("R1", "bank zero after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start on the wrong port is ignored
        dir_up = 1'b1;
        port_b_i = 1'b1;
        pix_bus = '1;
        @(negedge clk);
        port_b_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_ports(1'b1, 1'b0, "no carry after wrong-port start");
        end
        compare_all("R2", "bank after wrong-port start");

        run_frame(1'b1, 0, 1'b0);   // upward (R2, R4, R6, R7, R8)
        run_frame(1'b0, 1, 1'b0);   // downward (R5)
        run_frame(1'b1, 2, 1'b1);   // upward with mid-frame start (R10)
        run_frame(1'b0, 3, 1'b1);   // downward with mid-frame start (R10)

        finish_run();
    end
endmodule